// File: doc/BRIEF.md
# Timer Event Status Flags

This block keeps the sticky status flags of a multi-channel control timer. The timer core sends it one-cycle event strobes and level inputs: counter overflow and underflow, software and trigger reinitialisation, per-channel compare matches and captures, trigger edges, commutation events and three break inputs. Each flag is set by hardware when its qualifying condition holds. Software clears a flag by writing zero to its bit. A capture flag also clears when its capture register is read.

Each flag is ANDed with its enable bit, and the results are ORed into a single interrupt request. The system break flag also drives a restart-permit output. That output blocks PWM restart until the flag is cleared. The counter, prescaler, compare datapath and output stage live elsewhere; this block only decides when each flag is set, held or cleared, and it raises the overcapture flags.

Top module: `tmr_evflags`

## Requirements
- R1: After reset, every flag is 0, `irq` is 0 and `pwm_restart_ok` is 1.
- R2: Flag bit 0 (update) is set by `ovf_evt` or `unf_evt` only when `rep_zero` is 1 and `upd_dis` is 0.
- R3: `sw_reinit` or `trg_reinit` sets flag bit 0 only when `upd_src_restrict` is 0 and `upd_dis` is 0.
- R4: A channel in output mode sets its flag (bit 1+i for channel i, counting from 0) on `cmp_match[i]` when `cmp_above[i]` is 0. When `cmp_above[i]` is 1, it sets the flag on `ovf_evt` in up (`cnt_mode`=0) or centre (`cnt_mode`=2) counting, and on `unf_evt` in down counting (`cnt_mode`=1). While a channel is in input mode, compare events do not set its flag.
- R5: A channel in input mode (`ch_is_input[i]`=1) sets its flag on `cap_evt[i]`. While the channel is in input mode, `cap_rd[i]` clears that flag. In output mode, `cap_rd[i]` has no effect.
- R6: Overcapture flag bit NUM_CH+6+i is set when `cap_evt[i]` arrives in input mode while channel flag i is already set. Captures in output mode never set it. Only the first NUM_CAP channels have overcapture flags.
- R7: Channels NUM_CAP and above are output only: only compare conditions set their flags (bits 5 and 6 by default).
- R8: Trigger flag bit NUM_CH+2 is set when `slave_en` is 1 and either `slave_gated` is 0 and `trg_edge` is 1, or `slave_gated` is 1 and `gate_start_stop` is 1.
- R9: `com_evt` sets flag bit NUM_CH+1.
- R10: Break flags (bits NUM_CH+3, +4, +5 for `brk_in`, `brk2_in`, `sysbrk_in`) are set on every cycle their input is high. A software clear has no effect while the input stays high.
- R11: `pwm_restart_ok` is 0 whenever the system break flag is set.
- R12: When `wr_en` is 1, each `wr_data` bit at 0 clears its flag and each bit at 1 leaves its flag unchanged. A hardware set in the same cycle as a clear leaves the flag set.
- R13: `irq` is 1 exactly when some flag and its `irq_en` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_mode | input | 2 | Counting mode: 0 up, 1 down, 2 centre |
| ovf_evt | input | 1 | Counter overflow strobe |
| unf_evt | input | 1 | Counter underflow strobe |
| rep_zero | input | 1 | Repetition counter is zero |
| upd_dis | input | 1 | Update event generation disabled |
| upd_src_restrict | input | 1 | Only over/underflow may raise the update flag |
| sw_reinit | input | 1 | Software counter reinitialisation strobe |
| trg_reinit | input | 1 | Trigger counter reinitialisation strobe |
| cmp_match | input | NUM_CH | Counter equals compare value, per channel |
| cmp_above | input | NUM_CH | Compare value exceeds auto-reload, per channel |
| ch_is_input | input | NUM_CAP | Channel in input capture mode |
| cap_evt | input | NUM_CAP | Capture strobe |
| cap_rd | input | NUM_CAP | Capture register read strobe |
| slave_en | input | 1 | Slave controller enabled |
| slave_gated | input | 1 | Slave controller in gated mode |
| trg_edge | input | 1 | Active trigger edge strobe |
| gate_start_stop | input | 1 | Counter start or stop in gated mode |
| com_evt | input | 1 | Commutation control update strobe |
| brk_in | input | 1 | Break input, active high |
| brk2_in | input | 1 | Second break input, active high |
| sysbrk_in | input | 1 | System break input, active high |
| wr_en | input | 1 | Flag register write strobe |
| wr_data | input | NUM_CH+NUM_CAP+6 | Write data, zero clears |
| irq_en | input | NUM_CH+NUM_CAP+6 | Per-flag interrupt enables |
| flags | output | NUM_CH+NUM_CAP+6 | Flag vector |
| irq | output | 1 | Combined interrupt request |
| pwm_restart_ok | output | 1 | PWM restart permitted |

## Verification
The bound checker watches, on every cycle, the causes that allow the update and overcapture flags to rise. It also checks that break flags hold while their inputs are high, that a capture read in input mode clears its flag, that a write of one never clears a set flag, that the restart permit drops under system break, and that `irq` stays low when no enabled flag is set. Only the bench scenarios can show the things that need a known history: the compare-above-reload direction choice, the precedence of a set over a same-cycle clear, read strobes being ignored in output mode, and the gated and non-gated trigger rules.

// File: rtl/tmr_evflags_pkg.sv
package tmr_evflags_pkg;

   typedef enum logic [1:0] {
      CNT_UP     = 2'd0,
      CNT_DOWN   = 2'd1,
      CNT_CENTER = 2'd2
   } cnt_mode_e;

   // Flag vector: update, channels, com, trigger, three breaks, overcaptures
   function automatic int flag_width(input int nch, input int ncap);
      return nch + ncap + 6;
   endfunction

endpackage

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= RST_VAL;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/tmr_evflags_setgen.sv
module tmr_evflags_setgen (
   input  logic ovf_evt,
   input  logic unf_evt,
   input  logic rep_zero,
   input  logic upd_dis,
   input  logic upd_src_restrict,
   input  logic sw_reinit,
   input  logic trg_reinit,
   input  logic slave_en,
   input  logic slave_gated,
   input  logic trg_edge,
   input  logic gate_start_stop,
   output logic upd_set_o,
   output logic trg_set_o
);
   logic wrap_upd, reinit_upd;

   always_comb begin
      wrap_upd   = (ovf_evt | unf_evt) & rep_zero;
      reinit_upd = (sw_reinit | trg_reinit) & ~upd_src_restrict;
      upd_set_o  = ~upd_dis & (wrap_upd | reinit_upd);
      trg_set_o  = slave_en & (slave_gated ? gate_start_stop : trg_edge);
   end
endmodule

// File: rtl/tmr_chan_flag.sv
module tmr_chan_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic is_input,
   input  logic cap_evt,
   input  logic cap_rd,
   input  logic cmp_match,
   input  logic cmp_above,
   input  logic ovf_evt,
   input  logic unf_evt,
   input  logic cnt_down,
   input  logic sw_clr,
   output logic flag_o
);
   logic cmp_hit, set_c, clr_c;

   always_comb begin
      if (cmp_above) cmp_hit = cnt_down ? unf_evt : ovf_evt;
      else           cmp_hit = cmp_match;
      set_c = is_input ? cap_evt : cmp_hit;
      clr_c = sw_clr | (is_input & cap_rd);
   end

   tmr_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_c),
      .clr_i (clr_c),
      .q_o   (flag_o)
   );
endmodule

// File: rtl/tmr_evflags.sv
module tmr_evflags
   import tmr_evflags_pkg::*;
#(
   parameter int NUM_CH  = 6,
   parameter int NUM_CAP = 4,
   localparam int FLAG_W = flag_width(NUM_CH, NUM_CAP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cnt_mode,
   input  logic              ovf_evt,
   input  logic              unf_evt,
   input  logic              rep_zero,
   input  logic              upd_dis,
   input  logic              upd_src_restrict,
   input  logic              sw_reinit,
   input  logic              trg_reinit,
   input  logic [NUM_CH-1:0] cmp_match,
   input  logic [NUM_CH-1:0] cmp_above,
   input  logic [NUM_CAP-1:0] ch_is_input,
   input  logic [NUM_CAP-1:0] cap_evt,
   input  logic [NUM_CAP-1:0] cap_rd,
   input  logic              slave_en,
   input  logic              slave_gated,
   input  logic              trg_edge,
   input  logic              gate_start_stop,
   input  logic              com_evt,
   input  logic              brk_in,
   input  logic              brk2_in,
   input  logic              sysbrk_in,
   input  logic              wr_en,
   input  logic [FLAG_W-1:0] wr_data,
   input  logic [FLAG_W-1:0] irq_en,
   output logic [FLAG_W-1:0] flags,
   output logic              irq,
   output logic              pwm_restart_ok
);
   localparam int UPD_B  = 0;
   localparam int CH_B   = 1;
   localparam int COM_B  = NUM_CH + 1;
   localparam int TRG_B  = NUM_CH + 2;
   localparam int BRK_B  = NUM_CH + 3;
   localparam int NBRK   = 3;
   localparam int SBRK_B = BRK_B + NBRK - 1;
   localparam int OC_B   = BRK_B + NBRK;

   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_nch
      $error("tmr_evflags: NUM_CH must be 1..16");
   end
   if (NUM_CAP < 1 || NUM_CAP > NUM_CH) begin : g_bad_ncap
      $error("tmr_evflags: NUM_CAP must be 1..NUM_CH");
   end
   if (OC_B + NUM_CAP != FLAG_W) begin : g_bad_map
      $error("tmr_evflags: flag map does not fill the vector");
   end

   logic [FLAG_W-1:0] sw_clr;
   logic              cnt_down;
   logic              upd_set, trg_set;
   logic [NBRK-1:0]   brk_vec;

   assign sw_clr   = wr_en ? ~wr_data : '0;
   assign cnt_down = (cnt_mode_e'(cnt_mode) == CNT_DOWN);
   assign brk_vec  = {sysbrk_in, brk2_in, brk_in};

   tmr_evflags_setgen u_setgen (
      .ovf_evt          (ovf_evt),
      .unf_evt          (unf_evt),
      .rep_zero         (rep_zero),
      .upd_dis          (upd_dis),
      .upd_src_restrict (upd_src_restrict),
      .sw_reinit        (sw_reinit),
      .trg_reinit       (trg_reinit),
      .slave_en         (slave_en),
      .slave_gated      (slave_gated),
      .trg_edge         (trg_edge),
      .gate_start_stop  (gate_start_stop),
      .upd_set_o        (upd_set),
      .trg_set_o        (trg_set)
   );

   tmr_flag_cell u_upd (
      .clk (clk), .rst_n (rst_n),
      .set_i (upd_set), .clr_i (sw_clr[UPD_B]), .q_o (flags[UPD_B])
   );

   tmr_flag_cell u_com (
      .clk (clk), .rst_n (rst_n),
      .set_i (com_evt), .clr_i (sw_clr[COM_B]), .q_o (flags[COM_B])
   );

   tmr_flag_cell u_trg (
      .clk (clk), .rst_n (rst_n),
      .set_i (trg_set), .clr_i (sw_clr[TRG_B]), .q_o (flags[TRG_B])
   );

   // level-set breaks: an active input re-sets each cycle, beating any clear
   for (genvar b = 0; b < NBRK; b++) begin : g_brk
      tmr_flag_cell u_brk (
         .clk (clk), .rst_n (rst_n),
         .set_i (brk_vec[b]), .clr_i (sw_clr[BRK_B+b]), .q_o (flags[BRK_B+b])
      );
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      if (i < NUM_CAP) begin : g_cap
         tmr_chan_flag u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .is_input  (ch_is_input[i]),
            .cap_evt   (cap_evt[i]),
            .cap_rd    (cap_rd[i]),
            .cmp_match (cmp_match[i]),
            .cmp_above (cmp_above[i]),
            .ovf_evt   (ovf_evt),
            .unf_evt   (unf_evt),
            .cnt_down  (cnt_down),
            .sw_clr    (sw_clr[CH_B+i]),
            .flag_o    (flags[CH_B+i])
         );

         logic oc_set;
         assign oc_set = ch_is_input[i] & cap_evt[i] & flags[CH_B+i];

         tmr_flag_cell u_oc (
            .clk (clk), .rst_n (rst_n),
            .set_i (oc_set), .clr_i (sw_clr[OC_B+i]), .q_o (flags[OC_B+i])
         );
      end else begin : g_out
         tmr_chan_flag u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .is_input  (1'b0),
            .cap_evt   (1'b0),
            .cap_rd    (1'b0),
            .cmp_match (cmp_match[i]),
            .cmp_above (cmp_above[i]),
            .ovf_evt   (ovf_evt),
            .unf_evt   (unf_evt),
            .cnt_down  (cnt_down),
            .sw_clr    (sw_clr[CH_B+i]),
            .flag_o    (flags[CH_B+i])
         );
      end
   end

   assign irq            = |(flags & irq_en);
   assign pwm_restart_ok = ~flags[SBRK_B];

endmodule

// File: rtl/tmr_evflags_chk.sv
module tmr_evflags_chk
   import tmr_evflags_pkg::*;
#(
   parameter int NUM_CH  = 6,
   parameter int NUM_CAP = 4,
   localparam int FLAG_W = flag_width(NUM_CH, NUM_CAP)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cnt_mode,
   input logic              ovf_evt,
   input logic              unf_evt,
   input logic              rep_zero,
   input logic              upd_dis,
   input logic              upd_src_restrict,
   input logic              sw_reinit,
   input logic              trg_reinit,
   input logic [NUM_CH-1:0] cmp_match,
   input logic [NUM_CH-1:0] cmp_above,
   input logic [NUM_CAP-1:0] ch_is_input,
   input logic [NUM_CAP-1:0] cap_evt,
   input logic [NUM_CAP-1:0] cap_rd,
   input logic              slave_en,
   input logic              slave_gated,
   input logic              trg_edge,
   input logic              gate_start_stop,
   input logic              com_evt,
   input logic              brk_in,
   input logic              brk2_in,
   input logic              sysbrk_in,
   input logic              wr_en,
   input logic [FLAG_W-1:0] wr_data,
   input logic [FLAG_W-1:0] irq_en,
   input logic [FLAG_W-1:0] flags,
   input logic              irq,
   input logic              pwm_restart_ok
);
   localparam int BRK_B = NUM_CH + 3;
   localparam int OC_B  = NUM_CH + 6;

   // R2 R3: update flag rises only from a qualified cause
   a_r2_upd_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> $past(!upd_dis &&
         (((ovf_evt || unf_evt) && rep_zero) ||
          ((sw_reinit || trg_reinit) && !upd_src_restrict))));

   // R10: each break flag holds while its input is high
   a_r10_brk_hold: assert property (@(posedge clk) disable iff (!rst_n)
      brk_in |=> flags[BRK_B]);
   a_r10_brk2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      brk2_in |=> flags[BRK_B+1]);
   a_r10_sbrk_hold: assert property (@(posedge clk) disable iff (!rst_n)
      sysbrk_in |=> flags[BRK_B+2]);

   // R11: restart blocked after system break
   a_r11_restart_block: assert property (@(posedge clk) disable iff (!rst_n)
      sysbrk_in |=> !pwm_restart_ok);

   // R12: writing one never clears a set flag
   a_r12_w1_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[0] && flags[0]) |=> flags[0]);

   // R13: no enabled flag means no request
   a_r13_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & irq_en) == '0) |-> !irq);

   for (genvar i = 0; i < NUM_CAP; i++) begin : g_cap_chk
      // R6: overcapture needs a capture on an already-flagged input channel
      a_r6_oc_cause: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flags[OC_B+i]) |-> $past(cap_evt[i] && ch_is_input[i] && flags[1+i]));
      // R5: capture register read in input mode clears the flag
      a_r5_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_rd[i] && ch_is_input[i] && !cap_evt[i]) |=> !flags[1+i]);
   end
endmodule

bind tmr_evflags tmr_evflags_chk #(.NUM_CH(NUM_CH), .NUM_CAP(NUM_CAP)) u_chk (.*);

// File: tb/tmr_evflags_test.sv
`timescale 1ns/1ps
module tmr_evflags_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cnt_mode;
   logic        ovf_evt, unf_evt, rep_zero, upd_dis, upd_src_restrict;
   logic        sw_reinit, trg_reinit;
   logic [5:0]  cmp_match, cmp_above;
   logic [3:0]  ch_is_input, cap_evt, cap_rd;
   logic        slave_en, slave_gated, trg_edge, gate_start_stop, com_evt;
   logic        brk_in, brk2_in, sysbrk_in, wr_en;
   logic [15:0] wr_data, irq_en;
   logic [15:0] flags;
   logic        irq, pwm_restart_ok;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tmr_evflags uut (.*);

   typedef struct packed {
      logic ovf, unf, rz, udis, urs, ug;
      logic [1:0]  mode;
      logic [5:0]  match, above;
      logic [3:0]  isin, cap, rd;
      logic        wr;
      logic [15:0] wdata;
      logic [15:0] exp;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t TBL [NV] = '{
      '{ovf:1'b1, default:'0},                                   // R2 rep not zero
      '{ovf:1'b1, rz:1'b1, udis:1'b1, default:'0},               // R2 disabled
      '{ovf:1'b1, rz:1'b1, exp:16'h0001, default:'0},            // R2
      '{wr:1'b1, wdata:16'hFFFE, default:'0},                    // R12 clear
      '{ug:1'b1, urs:1'b1, default:'0},                          // R3 restricted
      '{ug:1'b1, exp:16'h0001, default:'0},                      // R3
      '{match:6'b000001, exp:16'h0003, default:'0},              // R4 match
      '{above:6'b000010, ovf:1'b1, exp:16'h0007, default:'0},    // R4 above, up
      '{wr:1'b1, default:'0},                                    // R12 clear all
      '{above:6'b000100, mode:2'd1, ovf:1'b1, default:'0},       // R4 down, ovf ignored
      '{above:6'b000100, mode:2'd1, unf:1'b1, exp:16'h0008, default:'0}, // R4 down
      '{match:6'b110000, exp:16'h0068, default:'0},              // R7
      '{wr:1'b1, wdata:16'hFFFF, exp:16'h0068, default:'0},      // R12 write ones
      '{wr:1'b1, match:6'b000001, exp:16'h0002, default:'0},     // R12 set wins
      '{isin:4'b0001, cap:4'b0001, exp:16'h1002, default:'0},    // R6 overcapture
      '{isin:4'b0001, rd:4'b0001, exp:16'h1000, default:'0},     // R5 read clear
      '{isin:4'b0001, cap:4'b0001, exp:16'h1002, default:'0},    // R5 capture set
      '{rd:4'b0001, exp:16'h1002, default:'0},                   // R5 read in output mode
      '{isin:4'b0010, match:6'b000010, exp:16'h1002, default:'0},// R4 input ignores compare
      '{cap:4'b0010, exp:16'h1002, default:'0},                  // R6 output capture ignored
      '{wr:1'b1, wdata:16'hEFFF, exp:16'h0002, default:'0}       // R6 oc clear
   };

   function automatic string vtag(input int i);
      if (i < 4)   return (i == 3) ? "R12" : "R2";
      if (i < 6)   return "R3";
      if (i < 8)   return "R4";
      if (i == 8)  return "R12";
      if (i < 11)  return "R4";
      if (i == 11) return "R7";
      if (i < 14)  return "R12";
      if (i == 14) return "R6";
      if (i < 18)  return "R5";
      if (i == 18) return "R4";
      return "R6";
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      cnt_mode = 2'd0; ovf_evt = 0; unf_evt = 0; rep_zero = 0; upd_dis = 0;
      upd_src_restrict = 0; sw_reinit = 0; trg_reinit = 0;
      cmp_match = '0; cmp_above = '0; ch_is_input = '0; cap_evt = '0; cap_rd = '0;
      slave_en = 0; slave_gated = 0; trg_edge = 0; gate_start_stop = 0; com_evt = 0;
      brk_in = 0; brk2_in = 0; sysbrk_in = 0; wr_en = 0; wr_data = '0;
   endtask

   // inputs applied at a falling edge; result sampled at the next falling edge
   task automatic step();
      @(negedge clk);
   endtask

   task automatic clear_all();
      idle(); wr_en = 1; wr_data = '0; step(); idle();
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      idle();
      irq_en = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 flags", flags, 16'h0000);
      chk("R1 irq", {15'd0, irq}, 16'h0000);
      chk("R1 restart", {15'd0, pwm_restart_ok}, 16'h0001);
      rst_n = 1'b1;
      step();

      for (int i = 0; i < NV; i++) begin
         idle();
         ovf_evt = TBL[i].ovf; unf_evt = TBL[i].unf; rep_zero = TBL[i].rz;
         upd_dis = TBL[i].udis; upd_src_restrict = TBL[i].urs; sw_reinit = TBL[i].ug;
         cnt_mode = TBL[i].mode; cmp_match = TBL[i].match; cmp_above = TBL[i].above;
         ch_is_input = TBL[i].isin; cap_evt = TBL[i].cap; cap_rd = TBL[i].rd;
         wr_en = TBL[i].wr; wr_data = TBL[i].wdata;
         step();
         chk(vtag(i), flags, TBL[i].exp);
      end
      clear_all();

      // R3 trigger reinit path, both gates
      trg_reinit = 1; upd_src_restrict = 1; step(); idle();
      chk("R3 trg reinit restricted", flags, 16'h0000);
      trg_reinit = 1; step(); idle();
      chk("R3 trg reinit", flags, 16'h0001);
      clear_all();

      // R4 centre counting uses overflow for above-reload
      cnt_mode = 2'd2; cmp_above = 6'b000001; unf_evt = 1; step(); idle();
      chk("R4 centre unf ignored", flags, 16'h0000);
      cnt_mode = 2'd2; cmp_above = 6'b000001; ovf_evt = 1; step(); idle();
      chk("R4 centre ovf", flags, 16'h0002);
      clear_all();

      // R8 trigger rules
      trg_edge = 1; step(); idle();
      chk("R8 slave off", flags, 16'h0000);
      slave_en = 1; slave_gated = 1; trg_edge = 1; step(); idle();
      chk("R8 gated edge", flags, 16'h0000);
      slave_en = 1; slave_gated = 1; gate_start_stop = 1; step(); idle();
      chk("R8 gated start", flags, 16'h0100);
      clear_all();
      slave_en = 1; trg_edge = 1; step(); idle();
      chk("R8 edge", flags, 16'h0100);
      clear_all();

      // R9 commutation
      com_evt = 1; step(); idle();
      chk("R9 com", flags, 16'h0080);

      // R13 interrupt enable
      irq_en = 16'hFF7F; #1;
      chk("R13 masked", {15'd0, irq}, 16'h0000);
      irq_en = 16'h0080; #1;
      chk("R13 enabled", {15'd0, irq}, 16'h0001);
      irq_en = '0;
      clear_all();

      // R10 breaks: clear ignored while active, allowed once inactive
      brk_in = 1; brk2_in = 1; step();
      chk("R10 set", flags, 16'h0600);
      wr_en = 1; wr_data = '0; step();
      chk("R10 clear while active", flags, 16'h0600);
      idle(); step();
      chk("R10 held after release", flags, 16'h0600);
      clear_all();
      chk("R10 cleared", flags, 16'h0000);

      // R11 system break blocks restart until cleared
      sysbrk_in = 1; step(); idle();
      chk("R11 flag", flags, 16'h0800);
      chk("R11 blocked", {15'd0, pwm_restart_ok}, 16'h0000);
      step();
      chk("R11 still blocked", {15'd0, pwm_restart_ok}, 16'h0000);
      clear_all();
      chk("R11 permitted", {15'd0, pwm_restart_ok}, 16'h0001);

      // R1 reset mid-run
      com_evt = 1; step(); idle();
      rst_n = 0; #1;
      chk("R1 async reset", flags, 16'h0000);
      step(); rst_n = 1; step();
      summary();
   end
endmodule